// File: doc/BRIEF.md
# Prioritised Peripheral-to-Pin Crossbar

This block routes a fixed, ranked list of seventeen on-chip digital peripheral signals onto seventeen general port pins. The pins are ordered port 0 bits 0..7, then port 1 bits 0..7, then the single port 2 bit. Software writes one configuration word: per-resource enables, a 16-bit pin skip mask, the slave-select wiring mode, a global crossbar enable and a port latch. One clock later the pin map is rebuilt. The UART transmit/receive pair is pinned to fixed locations. Every other enabled resource, taken in rank order, lands on the lowest pin that is neither skipped nor already taken.

Assigned pins carry their peripheral's output value and output-enable, and feed the pin level back to that peripheral. Pins left free act as plain outputs driven from the port latch. For debug, each pin reports whether it is assigned and which resource index owns it.

Top module: `pin_crossbar`

## Requirements
- R1: The configuration inputs are captured on a clock edge where `cfg_we` is high, and the pins reflect them from that edge on. After reset, the crossbar is disabled and every resource is disabled.
- R2: The resource indices, from highest to lowest rank, are: 0 TX, 1 RX, 2 SCK, 3 MISO, 4 MOSI, 5 NSS, 6 SDA, 7 SCL, 8 CMP, 9 CMP_ASYNC, 10 SYSCLK, 11 PCA0, 12 PCA1, 13 PCA2, 14 PCA_CLK, 15 TMR0, 16 TMR1. Placement follows this order.
- R3: Resource 0 sits on pin 4 and resource 1 on pin 5 whenever each is enabled, even if the pin's skip bit is set. A disabled UART resource leaves its pin free for the walk.
- R4: Each other enabled resource takes the lowest-numbered pin that is not skipped and not already taken. No resource occupies more than one pin.
- R5: Skip bit i (0..7) masks pin i, and skip bit 8+i masks pin 8+i. No walked resource is ever placed on a masked pin. Pin 16 has no skip bit.
- R6: Resource 5 takes part only when `cfg_spi_4wire` is 1. Otherwise it consumes no pin.
- R7: An enabled resource that finds no free pin is unplaced, and its `res_in` bit reads 1.
- R8: An assigned pin drives `periph_out`/`periph_oe` of its owner, and the owner's `res_in` bit equals that pin's `pin_in`.
- R9: An unassigned pin drives `pin_out` from latch bit p with output-enable 1 while the crossbar is enabled.
- R10: While the crossbar enable is 0, every `pin_oe` is 0, no pin is assigned and every `res_in` bit is 1.
- R11: `pin_owner` field p (bits 5p+4..5p) holds the owner's index, or 31 when the pin is unassigned. `pin_assigned` bit p is 1 exactly when the pin has an owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_res_en | input | 17 | Per-resource enable, indexed by rank |
| cfg_skip | input | 16 | Pin skip mask, port 0 in bits 7:0 |
| cfg_spi_4wire | input | 1 | Slave-select is pinned out |
| cfg_xbar_en | input | 1 | Global crossbar enable |
| cfg_latch | input | 17 | Port latch value for unassigned pins |
| periph_out | input | 17 | Peripheral output values |
| periph_oe | input | 17 | Peripheral output enables |
| res_in | output | 17 | Pin level routed back to each resource |
| pin_in | input | 17 | Pin levels |
| pin_out | output | 17 | Pin output values |
| pin_oe | output | 17 | Pin output enables |
| pin_assigned | output | 17 | Pin owned by a resource |
| pin_owner | output | 85 | Owner index per pin, 5 bits each |

## Verification
The bench builds the block with its default parameters: 17 resources, 17 pins and two 8-bit skip ports. At this size, every skip pattern on port 0 can be swept against pseudo-random enable sets, port 1 masks and wiring modes. With only 17 pins, the full-skip and full-enable corners are reachable, so resources really do run out of pins and the overflow idle value is exercised. Hand-picked cases cover a UART pin that is also skipped, both slave-select modes and the crossbar-off state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   typedef enum int {
      RES_TX = 0, RES_RX, RES_SCK, RES_MISO, RES_MOSI, RES_NSS, RES_SDA,
      RES_SCL, RES_CMP, RES_CMP_ASYNC, RES_SYSCLK, RES_PCA0, RES_PCA1,
      RES_PCA2, RES_PCA_CLK, RES_TMR0, RES_TMR1
   } res_id_e;

   localparam int DEF_N_RES        = 17;
   localparam int DEF_N_PINS       = 17;
   localparam int DEF_PORT_W       = 8;
   localparam int DEF_N_SKIP_PORTS = 2;
   localparam int DEF_TX_PIN       = 4;
   localparam int DEF_RX_PIN       = 5;
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
   parameter int N_RES  = 17,
   parameter int N_PINS = 17,
   parameter int SKIP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [N_RES-1:0]  res_en_d,
   input  logic [SKIP_W-1:0] skip_d,
   input  logic              spi4_d,
   input  logic              xen_d,
   input  logic [N_PINS-1:0] latch_d,
   output logic [N_RES-1:0]  res_en_q,
   output logic [SKIP_W-1:0] skip_q,
   output logic              spi4_q,
   output logic              xen_q,
   output logic [N_PINS-1:0] latch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_en_q <= '0;
         skip_q   <= '0;
         spi4_q   <= 1'b0;
         xen_q    <= 1'b0;
         latch_q  <= '0;
      end else if (we) begin
         res_en_q <= res_en_d;
         skip_q   <= skip_d;
         spi4_q   <= spi4_d;
         xen_q    <= xen_d;
         latch_q  <= latch_d;
      end
   end

   assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(res_en_q) && $stable(skip_q) && $stable(xen_q)));
endmodule

// File: rtl/xbar_walk.sv
module xbar_walk #(
   parameter int N_RES   = 17,
   parameter int N_PINS  = 17,
   parameter int SKIP_W  = 16,
   parameter int TX_RES  = 0,
   parameter int RX_RES  = 1,
   parameter int TX_PIN  = 4,
   parameter int RX_PIN  = 5,
   parameter int SEL_RES = 5,
   localparam int RW = $clog2(N_RES + 1),
   localparam int PW = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
   input  logic [N_RES-1:0]              res_en,
   input  logic [SKIP_W-1:0]             skip,
   input  logic                          spi4,
   input  logic                          xen,
   output logic [N_PINS-1:0]             used,
   output logic [N_PINS-1:0][RW-1:0]     owner,
   output logic [N_RES-1:0]              has_pin,
   output logic [N_RES-1:0][PW-1:0]      res_pin
);
   localparam logic [RW-1:0] NONE = '1;

   logic [N_PINS-1:0] skip_ext;
   logic [N_RES-1:0]  en_eff;

   assign skip_ext = N_PINS'(skip);

   always_comb begin
      en_eff = xen ? res_en : '0;
      en_eff[SEL_RES] = en_eff[SEL_RES] & spi4;
   end

   always_comb begin
      logic [N_PINS-1:0] taken;
      logic              found;
      taken   = skip_ext;
      used    = '0;
      owner   = {N_PINS{NONE}};
      has_pin = '0;
      res_pin = '0;
      found   = 1'b0;
      if (en_eff[TX_RES]) begin
         taken[TX_PIN] = 1'b1; used[TX_PIN] = 1'b1;
         owner[TX_PIN] = RW'(TX_RES);
         has_pin[TX_RES] = 1'b1; res_pin[TX_RES] = PW'(TX_PIN);
      end
      if (en_eff[RX_RES]) begin
         taken[RX_PIN] = 1'b1; used[RX_PIN] = 1'b1;
         owner[RX_PIN] = RW'(RX_RES);
         has_pin[RX_RES] = 1'b1; res_pin[RX_RES] = PW'(RX_PIN);
      end
      for (int r = 0; r < N_RES; r++) begin
         if (r != TX_RES && r != RX_RES && en_eff[r]) begin
            found = 1'b0;
            for (int p = 0; p < N_PINS; p++) begin
               if (!found && !taken[p]) begin
                  found      = 1'b1;
                  taken[p]   = 1'b1;
                  used[p]    = 1'b1;
                  owner[p]   = RW'(r);
                  has_pin[r] = 1'b1;
                  res_pin[r] = PW'(p);
               end
            end
         end
      end
   end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux #(
   parameter int N_RES  = 17,
   parameter int N_PINS = 17,
   localparam int RW = $clog2(N_RES + 1),
   localparam int PW = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
   input  logic                      xen,
   input  logic [N_PINS-1:0]         used,
   input  logic [N_PINS-1:0][RW-1:0] owner,
   input  logic [N_RES-1:0]          has_pin,
   input  logic [N_RES-1:0][PW-1:0]  res_pin,
   input  logic [N_PINS-1:0]         latch,
   input  logic [N_RES-1:0]          periph_out,
   input  logic [N_RES-1:0]          periph_oe,
   input  logic [N_PINS-1:0]         pin_in,
   output logic [N_PINS-1:0]         pin_out,
   output logic [N_PINS-1:0]         pin_oe,
   output logic [N_RES-1:0]          res_in
);
   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      always_comb begin
         pin_out[p] = latch[p];
         pin_oe[p]  = xen;
         for (int r = 0; r < N_RES; r++) begin
            if (used[p] && owner[p] == RW'(r)) begin
               pin_out[p] = periph_out[r];
               pin_oe[p]  = xen & periph_oe[r];
            end
         end
      end
   end

   for (genvar r = 0; r < N_RES; r++) begin : g_res
      always_comb begin
         res_in[r] = 1'b1;
         for (int p = 0; p < N_PINS; p++) begin
            if (has_pin[r] && res_pin[r] == PW'(p)) res_in[r] = pin_in[p];
         end
      end
   end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar #(
   parameter int N_RES        = xbar_pkg::DEF_N_RES,
   parameter int N_PINS       = xbar_pkg::DEF_N_PINS,
   parameter int PORT_W       = xbar_pkg::DEF_PORT_W,
   parameter int N_SKIP_PORTS = xbar_pkg::DEF_N_SKIP_PORTS,
   parameter int TX_PIN       = xbar_pkg::DEF_TX_PIN,
   parameter int RX_PIN       = xbar_pkg::DEF_RX_PIN,
   localparam int SKIP_W = PORT_W * N_SKIP_PORTS,
   localparam int RW     = $clog2(N_RES + 1),
   localparam int PW     = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [N_RES-1:0]     cfg_res_en,
   input  logic [SKIP_W-1:0]    cfg_skip,
   input  logic                 cfg_spi_4wire,
   input  logic                 cfg_xbar_en,
   input  logic [N_PINS-1:0]    cfg_latch,
   input  logic [N_RES-1:0]     periph_out,
   input  logic [N_RES-1:0]     periph_oe,
   output logic [N_RES-1:0]     res_in,
   input  logic [N_PINS-1:0]    pin_in,
   output logic [N_PINS-1:0]    pin_out,
   output logic [N_PINS-1:0]    pin_oe,
   output logic [N_PINS-1:0]    pin_assigned,
   output logic [N_PINS*RW-1:0] pin_owner
);
   import xbar_pkg::*;

   localparam int TX_RES  = int'(RES_TX);
   localparam int RX_RES  = int'(RES_RX);
   localparam int SEL_RES = int'(RES_NSS);

   if (N_PINS < SKIP_W)   $error("skip mask wider than pin count");
   if (N_RES <= SEL_RES)  $error("resource list too short");
   if (TX_PIN >= N_PINS || RX_PIN >= N_PINS || TX_PIN == RX_PIN)
      $error("fixed UART pins invalid");

   logic [N_RES-1:0]          en_q;
   logic [SKIP_W-1:0]         skip_q;
   logic                      spi4_q, xen_q;
   logic [N_PINS-1:0]         latch_q;
   logic [N_PINS-1:0]         used;
   logic [N_PINS-1:0][RW-1:0] owner;
   logic [N_RES-1:0]          has_pin;
   logic [N_RES-1:0][PW-1:0]  res_pin;

   xbar_cfg_regs #(.N_RES(N_RES), .N_PINS(N_PINS), .SKIP_W(SKIP_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .res_en_d(cfg_res_en), .skip_d(cfg_skip), .spi4_d(cfg_spi_4wire),
      .xen_d(cfg_xbar_en), .latch_d(cfg_latch),
      .res_en_q(en_q), .skip_q(skip_q), .spi4_q(spi4_q), .xen_q(xen_q),
      .latch_q(latch_q));

   xbar_walk #(.N_RES(N_RES), .N_PINS(N_PINS), .SKIP_W(SKIP_W),
      .TX_RES(TX_RES), .RX_RES(RX_RES), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN),
      .SEL_RES(SEL_RES)) u_walk (
      .res_en(en_q), .skip(skip_q), .spi4(spi4_q), .xen(xen_q),
      .used(used), .owner(owner), .has_pin(has_pin), .res_pin(res_pin));

   xbar_pin_mux #(.N_RES(N_RES), .N_PINS(N_PINS)) u_mux (
      .xen(xen_q), .used(used), .owner(owner), .has_pin(has_pin),
      .res_pin(res_pin), .latch(latch_q), .periph_out(periph_out),
      .periph_oe(periph_oe), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .res_in(res_in));

   assign pin_assigned = used;
   assign pin_owner    = owner;

   logic [N_PINS-1:0] skip_ext, fixed_mask;
   assign skip_ext = N_PINS'(skip_q);
   always_comb begin
      fixed_mask = '0;
      fixed_mask[TX_PIN] = 1'b1;
      fixed_mask[RX_PIN] = 1'b1;
   end

   assert_uart_tx_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xen_q && en_q[TX_RES]) |-> (used[TX_PIN] && owner[TX_PIN] == RW'(TX_RES)));
   assert_uart_rx_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xen_q && en_q[RX_RES]) |-> (used[RX_PIN] && owner[RX_PIN] == RW'(RX_RES)));
   assert_skip_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (used & skip_ext & ~fixed_mask) == '0);
   assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !xen_q |-> (pin_oe == '0 && pin_assigned == '0));
   assert_cfg_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_xbar_en) |=> (pin_oe == '0));
   assert_nss_3wire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !spi4_q |-> !has_pin[SEL_RES]);

   for (genvar r = 0; r < N_RES; r++) begin : g_chk
      logic [N_PINS-1:0] hit;
      always_comb
         for (int p = 0; p < N_PINS; p++)
            hit[p] = used[p] && owner[p] == RW'(r);
      assert_single_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(hit) <= 1);
      assert_unplaced_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (hit == '0) |-> res_in[r]);
   end
endmodule

// File: tb/pin_crossbar_test.sv
module pin_crossbar_test;
   localparam int NR = 17;
   localparam int NP = 17;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [NR-1:0] cfg_res_en = '0;
   logic [15:0]   cfg_skip = '0;
   logic          cfg_spi_4wire = 1'b0;
   logic          cfg_xbar_en = 1'b0;
   logic [NP-1:0] cfg_latch = '0;
   logic [NR-1:0] periph_out = '0, periph_oe = '0, res_in;
   logic [NP-1:0] pin_in = '0, pin_out, pin_oe, pin_assigned;
   logic [NP*RW-1:0] pin_owner;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   pin_crossbar uut (.*);

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [NR-1:0] en, input logic [15:0] sk,
                        input logic s4, input logic xe, input logic [NP-1:0] lt);
      @(negedge clk);
      cfg_res_en = en; cfg_skip = sk; cfg_spi_4wire = s4;
      cfg_xbar_en = xe; cfg_latch = lt; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
   endtask

   // Expected map from the placement rules; returns owner per pin (-1 none)
   task automatic expect_all(input string tag);
      int own[NP];
      int rpin[NR];
      logic [NP-1:0] taken;
      logic [NR-1:0] en2;
      logic [NP*RW-1:0] e_owner;
      logic [NP-1:0] e_asg, e_out, e_oe;
      logic [NR-1:0] e_rin;
      for (int p = 0; p < NP; p++) begin
         own[p] = -1;
         taken[p] = (p < 16) ? cfg_skip[p] : 1'b0;
      end
      for (int r = 0; r < NR; r++) rpin[r] = -1;
      en2 = cfg_xbar_en ? cfg_res_en : '0;
      en2[5] = en2[5] & cfg_spi_4wire;
      if (en2[0]) begin own[4] = 0; taken[4] = 1'b1; rpin[0] = 4; end
      if (en2[1]) begin own[5] = 1; taken[5] = 1'b1; rpin[1] = 5; end
      for (int r = 2; r < NR; r++) begin
         if (en2[r]) begin
            for (int p = 0; p < NP; p++) begin
               if (rpin[r] < 0 && !taken[p]) begin
                  own[p] = r; taken[p] = 1'b1; rpin[r] = p;
               end
            end
         end
      end
      for (int p = 0; p < NP; p++) begin
         e_owner[p*RW +: RW] = (own[p] < 0) ? 5'd31 : RW'(own[p]);
         e_asg[p] = own[p] >= 0;
         e_out[p] = (own[p] < 0) ? cfg_latch[p] : periph_out[own[p]];
         e_oe[p]  = cfg_xbar_en & ((own[p] < 0) ? 1'b1 : periph_oe[own[p]]);
      end
      for (int r = 0; r < NR; r++) e_rin[r] = (rpin[r] < 0) ? 1'b1 : pin_in[rpin[r]];
      check({tag, " R11 owner"}, 128'(pin_owner), 128'(e_owner));
      check({tag, " R4 assigned"}, 128'(pin_assigned), 128'(e_asg));
      check({tag, " R8 R9 pin_out"}, 128'(pin_out), 128'(e_out));
      check({tag, " R8 R9 pin_oe"}, 128'(pin_oe), 128'(e_oe));
      check({tag, " R7 R8 res_in"}, 128'(res_in), 128'(e_rin));
   endtask

   task automatic stir();
      seed = nxt(seed); periph_out = seed[NR-1:0];
      seed = nxt(seed); periph_oe  = seed[NR-1:0];
      seed = nxt(seed); pin_in     = seed[NP-1:0];
      #1;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset oe", 128'(pin_oe), 128'(0));
      check("R1 reset assigned", 128'(pin_assigned), 128'(0));
      check("R1 reset res_in", 128'(res_in), {111'd0, {NR{1'b1}}});
      stir();

      // R5: port 0 pins 2,3 skipped; UART + SCK, MISO, MOSI -> pins 0,1,6
      apply(17'h0001F, 16'h000C, 1'b0, 1'b1, 17'h0_AAAA);
      check("R5 sck pin0", 128'(pin_owner[0*RW +: RW]), 128'(2));
      check("R5 miso pin1", 128'(pin_owner[1*RW +: RW]), 128'(3));
      check("R5 mosi pin6", 128'(pin_owner[6*RW +: RW]), 128'(4));
      expect_all("R5");

      // R1: new config not visible before the capturing edge
      @(negedge clk);
      cfg_xbar_en = 1'b0; cfg_res_en = '0;
      #1;
      check("R1 before write", 128'(pin_assigned[4]), 128'(1));

      // R2: all resources, no skips, 4-wire
      apply('1, 16'h0000, 1'b1, 1'b1, 17'h1_5555);
      stir(); expect_all("R2");
      check("R2 tmr1 last pin", 128'(pin_owner[16*RW +: RW]), 128'(16));

      // R3: UART disabled -> pins 4,5 free; SCK..SCL land on 0..5
      apply(17'h000FC, 16'h0000, 1'b1, 1'b1, '0);
      check("R3 pin4 reused", 128'(pin_owner[4*RW +: RW]), 128'(6));
      expect_all("R3");
      // R3: UART on a skipped pin still placed
      apply(17'h00007, 16'h0030, 1'b0, 1'b1, '0);
      check("R3 tx on skipped pin", 128'(pin_owner[4*RW +: RW]), 128'(0));
      expect_all("R3");

      // R6: slave-select only in 4-wire mode
      apply(17'h00020, 16'h0000, 1'b0, 1'b1, '0);
      check("R6 3wire", 128'(pin_assigned), 128'(0));
      apply(17'h00020, 16'h0000, 1'b1, 1'b1, '0);
      check("R6 4wire", 128'(pin_owner[0*RW +: RW]), 128'(5));

      // R7: port 0 and 1 fully skipped; only pin 16 free for walkers
      apply('1, 16'hFFFF, 1'b1, 1'b1, '0);
      stir(); expect_all("R7");
      check("R7 mosi unplaced", 128'(res_in[4]), 128'(1));

      // R10: crossbar off
      apply('1, 16'h0000, 1'b1, 1'b0, '1);
      stir();
      check("R10 oe", 128'(pin_oe), 128'(0));
      expect_all("R10");

      // R9: free pins follow latch
      apply(17'h0, 16'h0000, 1'b0, 1'b1, 17'h1_3C5A);
      check("R9 latch out", 128'(pin_out), 128'(17'h1_3C5A));

      // Sweep every port 0 skip pattern with pseudo-random settings
      for (int s = 0; s < 256; s++) begin
         logic [31:0] a, b;
         seed = nxt(seed); a = seed;
         seed = nxt(seed); b = seed;
         apply(a[NR-1:0], {b[7:0] & b[15:8], 8'(s)}, a[20], (b[31:28] != 0), b[NP+8:9]);
         stir();
         expect_all("R4 sweep");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule